// File: doc/BRIEF.md
# Processing-Unit Dispatcher and Result Merger

This block sits between the stage that assembles executable packages and a pool of identical processing units. Each package that arrives on the upstream valid/ready port goes to any unit that is idle at that moment. A round-robin pointer spreads the work evenly over the pool. The block keeps one busy flag per unit. A unit counts as busy from the cycle its package is accepted until the cycle its final result beat is taken. When no unit is idle, the upstream ready is held low, so the surrounding pipeline ring stalls through ordinary backpressure.

On the return side, each unit presents result beats on its own valid/ready port. An instruction may yield zero, one or two result tokens. Each beat carries a "last" flag, and a "void" flag for an instruction that produces nothing. A second round-robin arbiter picks one busy unit with a pending beat each cycle and passes its token onward on a single output stream. A void beat only retires the unit and produces no token. Results from different units may leave in any order.

Top module: `pu_dispatch`

## Requirements
- R1: After a synchronous active-high reset, with every unit_ready_i bit high, pkg_ready_o is high and unit_valid_o, res_ready_o and tok_valid_o are all zero.
- R2: At most one bit of unit_valid_o is high in any cycle. It is high only while pkg_valid_i is high, and never for a unit that is busy.
- R3: The search for an idle unit starts at the unit after the one most recently given a package, and wraps from N_UNITS-1 to 0. After reset it starts at unit 0.
- R4: While every unit is busy, pkg_ready_o is low and unit_valid_o is zero, whatever pkg_valid_i does.
- R5: A unit becomes busy in the cycle after its package handshake. It stays busy up to and including the cycle in which its beat with res_last_i=1 is accepted. It can first be offered a new package in the following cycle.
- R6: Every non-void beat accepted from a busy unit appears once on tok_data_o, with tok_valid_o high. The stream carries up to two tokens per instruction, and res_ready_o is never high for a unit whose res_valid_i is low.
- R7: A beat with res_void_i=1 (always sent with res_last_i=1) is accepted without producing a token. tok_valid_o stays low in that cycle, and the unit is free in the next cycle.
- R8: Result selection is round-robin among busy units with res_valid_i high. It starts at the unit after the one last granted, and at most one res_ready_o bit is high per cycle.
- R9: While tok_ready_i is low, no non-void beat is accepted: res_ready_o is zero for every unit presenting a token.
- R10: A result presented by a unit that is not busy is never accepted and never reaches the token output.
- R11: The pool size defaults to ten units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pkg_valid_i | input | 1 | Upstream package present |
| pkg_ready_o | output | 1 | Package can be taken this cycle |
| pkg_data_i | input | PKG_W | Executable package |
| unit_valid_o | output | N_UNITS | Package offered to unit i |
| unit_ready_i | input | N_UNITS | Unit i can take a package |
| unit_pkg_o | output | N_UNITS*PKG_W | Package copy to each unit, slice i for unit i |
| res_valid_i | input | N_UNITS | Unit i presents a result beat |
| res_ready_o | output | N_UNITS | Beat of unit i accepted |
| res_last_i | input | N_UNITS | Beat is the final one of the instruction |
| res_void_i | input | N_UNITS | Beat carries no token (zero-output instruction) |
| res_data_i | input | N_UNITS*TOK_W | Result token of each unit, slice i for unit i |
| tok_valid_o | output | 1 | Token present toward the token queue |
| tok_ready_i | input | 1 | Token queue takes the token |
| tok_data_o | output | TOK_W | Forwarded result token |

## Verification
Two functions can meet in one cycle: a unit's final result is retired while a waiting package looks for a free unit. To provoke this, the bench fills the pool, keeps a package pending, and releases exactly one unit. In the cycle that unit's last beat is accepted, pkg_ready_o must still be low. In the next cycle the package must be offered to that unit and no other. A second collision sets a void beat against the token stream, and the check there is that tok_valid_o stays low while the unit retires.

// File: rtl/pu_dispatch_pkg.sv
package pu_dispatch_pkg;

    localparam int DEF_UNITS = 10;
    localparam int DEF_PKG_W = 16;
    localparam int DEF_TOK_W = 16;

    // Flags describing the beat selected by the result merger.
    typedef struct packed {
        logic last;
        logic empty;
    } beat_tag_t;

    // Width of an index over n items (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pu_rr_pick.sv
module pu_rr_pick #(
    parameter int N_REQ = 10,
    parameter int IDX_W = 4
) (
    input  logic [N_REQ-1:0] req_i,
    input  logic [IDX_W-1:0] ptr_i,
    output logic [IDX_W-1:0] grant_o,
    output logic             found_o
);

    localparam int SUM_W = IDX_W + 1;

    // Scan from ptr_i upward with wrap; the nearest request wins.
    always_comb begin
        logic [SUM_W-1:0] idx;
        found_o = 1'b0;
        grant_o = '0;
        idx     = '0;
        for (int k = N_REQ - 1; k >= 0; k--) begin
            idx = {1'b0, ptr_i} + SUM_W'(k);
            if (idx >= SUM_W'(N_REQ)) begin
                idx = idx - SUM_W'(N_REQ);
            end
            if (req_i[idx[IDX_W-1:0]]) begin
                found_o = 1'b1;
                grant_o = idx[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/pu_unit_track.sv
module pu_unit_track #(
    parameter int N_UNITS = 10,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pkg_valid_i,
    input  logic [N_UNITS-1:0] unit_ready_i,
    input  logic [N_UNITS-1:0] done_i,
    output logic [N_UNITS-1:0] unit_valid_o,
    output logic               pkg_ready_o,
    output logic [N_UNITS-1:0] busy_o
);

    localparam logic [N_UNITS-1:0] ONE = N_UNITS'(1);
    localparam logic [IDX_W-1:0]   TOP = IDX_W'(N_UNITS - 1);

    logic [N_UNITS-1:0] busy_q;
    logic [IDX_W-1:0]   ptr_q;
    logic [IDX_W-1:0]   sel;
    logic               found;
    logic               fire;

    pu_rr_pick #(.N_REQ(N_UNITS), .IDX_W(IDX_W)) u_free_pick (
        .req_i   (~busy_q),
        .ptr_i   (ptr_q),
        .grant_o (sel),
        .found_o (found)
    );

    always_comb begin
        pkg_ready_o  = found & unit_ready_i[sel];
        unit_valid_o = (pkg_valid_i && found) ? (ONE << sel) : '0;
        fire         = pkg_valid_i & pkg_ready_o;
    end

    // A retiring unit keeps its busy bit through the retiring cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            ptr_q  <= '0;
        end else begin
            busy_q <= (busy_q & ~done_i) | (fire ? (ONE << sel) : '0);
            if (fire) begin
                ptr_q <= (sel == TOP) ? '0 : sel + IDX_W'(1);
            end
        end
    end

    assign busy_o = busy_q;

endmodule

// File: rtl/pu_result_merge.sv
module pu_result_merge
    import pu_dispatch_pkg::*;
#(
    parameter int N_UNITS = 10,
    parameter int TOK_W   = 16,
    parameter int IDX_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_UNITS-1:0]         busy_i,
    input  logic [N_UNITS-1:0]         res_valid_i,
    input  logic [N_UNITS-1:0]         res_last_i,
    input  logic [N_UNITS-1:0]         res_void_i,
    input  logic [N_UNITS*TOK_W-1:0]   res_data_i,
    input  logic                       tok_ready_i,
    output logic [N_UNITS-1:0]         res_ready_o,
    output logic                       tok_valid_o,
    output logic [TOK_W-1:0]           tok_data_o,
    output logic [N_UNITS-1:0]         done_o
);

    localparam logic [N_UNITS-1:0] ONE = N_UNITS'(1);
    localparam logic [IDX_W-1:0]   TOP = IDX_W'(N_UNITS - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] gnt;
    logic             found;
    logic             take;
    beat_tag_t        tag;

    pu_rr_pick #(.N_REQ(N_UNITS), .IDX_W(IDX_W)) u_res_pick (
        .req_i   (res_valid_i & busy_i),
        .ptr_i   (ptr_q),
        .grant_o (gnt),
        .found_o (found)
    );

    always_comb begin
        tag.last    = res_last_i[gnt];
        tag.empty   = res_void_i[gnt];
        tok_data_o  = res_data_i[int'(gnt)*TOK_W +: TOK_W];
        tok_valid_o = found & ~tag.empty;
        take        = found & (tag.empty | tok_ready_i);
        res_ready_o = take ? (ONE << gnt) : '0;
        done_o      = (take && tag.last) ? (ONE << gnt) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (take) begin
            ptr_q <= (gnt == TOP) ? '0 : gnt + IDX_W'(1);
        end
    end

endmodule

// File: rtl/pu_dispatch.sv
module pu_dispatch
    import pu_dispatch_pkg::*;
#(
    parameter int N_UNITS = DEF_UNITS,
    parameter int PKG_W   = DEF_PKG_W,
    parameter int TOK_W   = DEF_TOK_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pkg_valid_i,
    output logic                       pkg_ready_o,
    input  logic [PKG_W-1:0]           pkg_data_i,
    output logic [N_UNITS-1:0]         unit_valid_o,
    input  logic [N_UNITS-1:0]         unit_ready_i,
    output logic [N_UNITS*PKG_W-1:0]   unit_pkg_o,
    input  logic [N_UNITS-1:0]         res_valid_i,
    output logic [N_UNITS-1:0]         res_ready_o,
    input  logic [N_UNITS-1:0]         res_last_i,
    input  logic [N_UNITS-1:0]         res_void_i,
    input  logic [N_UNITS*TOK_W-1:0]   res_data_i,
    output logic                       tok_valid_o,
    input  logic                       tok_ready_i,
    output logic [TOK_W-1:0]           tok_data_o
);

    localparam int IDX_W = idx_width(N_UNITS);

    logic [N_UNITS-1:0] busy_w;
    logic [N_UNITS-1:0] done_w;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_fan
        assign unit_pkg_o[u*PKG_W +: PKG_W] = pkg_data_i;
    end

    pu_unit_track #(.N_UNITS(N_UNITS), .IDX_W(IDX_W)) u_track (
        .clk          (clk),
        .rst          (rst),
        .pkg_valid_i  (pkg_valid_i),
        .unit_ready_i (unit_ready_i),
        .done_i       (done_w),
        .unit_valid_o (unit_valid_o),
        .pkg_ready_o  (pkg_ready_o),
        .busy_o       (busy_w)
    );

    pu_result_merge #(.N_UNITS(N_UNITS), .TOK_W(TOK_W), .IDX_W(IDX_W)) u_merge (
        .clk         (clk),
        .rst         (rst),
        .busy_i      (busy_w),
        .res_valid_i (res_valid_i),
        .res_last_i  (res_last_i),
        .res_void_i  (res_void_i),
        .res_data_i  (res_data_i),
        .tok_ready_i (tok_ready_i),
        .res_ready_o (res_ready_o),
        .tok_valid_o (tok_valid_o),
        .tok_data_o  (tok_data_o),
        .done_o      (done_w)
    );

endmodule

// File: rtl/pu_dispatch_chk.sv
module pu_dispatch_chk #(
    parameter int N_UNITS = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               pkg_valid_i,
    input logic               pkg_ready_o,
    input logic [N_UNITS-1:0] unit_valid_o,
    input logic [N_UNITS-1:0] unit_ready_i,
    input logic [N_UNITS-1:0] res_valid_i,
    input logic [N_UNITS-1:0] res_ready_o,
    input logic [N_UNITS-1:0] res_last_i,
    input logic [N_UNITS-1:0] res_void_i,
    input logic               tok_valid_o,
    input logic               tok_ready_i,
    input logic [N_UNITS-1:0] busy_q
);

    logic armed_q;
    always_ff @(posedge clk) armed_q <= !rst;

    p_one_offer_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(unit_valid_o));

    p_offer_needs_pkg_r2: assert property (@(posedge clk) disable iff (rst)
        (unit_valid_o != '0) |-> pkg_valid_i);

    p_offer_free_r2: assert property (@(posedge clk) disable iff (rst)
        (unit_valid_o & busy_q) == '0);

    p_full_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (&busy_q) |-> (!pkg_ready_o && unit_valid_o == '0));

    p_busy_set_r5: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> ((busy_q & ~$past(busy_q)) == $past(unit_valid_o & unit_ready_i)));

    p_busy_clear_r5: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> (($past(busy_q) & ~busy_q) == $past(res_ready_o & res_last_i)));

    p_ack_valid_r6: assert property (@(posedge clk) disable iff (rst)
        (res_ready_o & ~res_valid_i) == '0);

    p_void_silent_r7: assert property (@(posedge clk) disable iff (rst)
        ((res_ready_o & res_void_i) != '0) |-> !tok_valid_o);

    p_one_ack_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(res_ready_o));

    p_backpress_r9: assert property (@(posedge clk) disable iff (rst)
        !tok_ready_i |-> ((res_ready_o & ~res_void_i) == '0));

    p_idle_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (res_ready_o & ~busy_q) == '0);

endmodule

bind pu_dispatch pu_dispatch_chk #(.N_UNITS(N_UNITS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pkg_valid_i  (pkg_valid_i),
    .pkg_ready_o  (pkg_ready_o),
    .unit_valid_o (unit_valid_o),
    .unit_ready_i (unit_ready_i),
    .res_valid_i  (res_valid_i),
    .res_ready_o  (res_ready_o),
    .res_last_i   (res_last_i),
    .res_void_i   (res_void_i),
    .tok_valid_o  (tok_valid_o),
    .tok_ready_i  (tok_ready_i),
    .busy_q       (busy_w)
);

// File: tb/pu_dispatch_test.sv
`timescale 1ns/1ps
module pu_dispatch_test;

    localparam int N  = 10;
    localparam int PW = 16;
    localparam int TW = 16;
    localparam int NV = 20;

    // Package: [15:8] id, [7:6] token count (0..2), [5:0] latency in cycles.
    // Token produced for result k of a package: {id, k}.
    localparam logic [15:0] VEC [0:NV-1] = '{
        {8'h01,2'd1,6'd3}, {8'h02,2'd2,6'd0}, {8'h03,2'd0,6'd1}, {8'h04,2'd2,6'd7},
        {8'h05,2'd1,6'd0}, {8'h06,2'd2,6'd2}, {8'h07,2'd1,6'd9}, {8'h08,2'd0,6'd0},
        {8'h09,2'd2,6'd4}, {8'h0A,2'd1,6'd1}, {8'h0B,2'd2,6'd6}, {8'h0C,2'd1,6'd0},
        {8'h0D,2'd0,6'd5}, {8'h0E,2'd2,6'd1}, {8'h0F,2'd1,6'd8}, {8'h10,2'd2,6'd0},
        {8'h11,2'd1,6'd2}, {8'h12,2'd0,6'd3}, {8'h13,2'd2,6'd5}, {8'h14,2'd1,6'd0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pkg_valid_i = 1'b0;
    logic              pkg_ready_o;
    logic [PW-1:0]     pkg_data_i = '0;
    logic [N-1:0]      unit_valid_o;
    logic [N-1:0]      unit_ready_i;
    logic [N*PW-1:0]   unit_pkg_o;
    logic [N-1:0]      res_valid_i;
    logic [N-1:0]      res_ready_o;
    logic [N-1:0]      res_last_i;
    logic [N-1:0]      res_void_i;
    logic [N*TW-1:0]   res_data_i;
    logic              tok_valid_o;
    logic              tok_ready_i;
    logic [TW-1:0]     tok_data_o;

    pu_dispatch uut (
        .clk(clk), .rst(rst),
        .pkg_valid_i(pkg_valid_i), .pkg_ready_o(pkg_ready_o), .pkg_data_i(pkg_data_i),
        .unit_valid_o(unit_valid_o), .unit_ready_i(unit_ready_i), .unit_pkg_o(unit_pkg_o),
        .res_valid_i(res_valid_i), .res_ready_o(res_ready_o), .res_last_i(res_last_i),
        .res_void_i(res_void_i), .res_data_i(res_data_i),
        .tok_valid_o(tok_valid_o), .tok_ready_i(tok_ready_i), .tok_data_o(tok_data_o)
    );

    always #10 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int busy_offer_viol = 0;
    int stray_taken = 0;
    int bad_tok = 0;
    int tok_n = 0;
    int tok_seen [0:511];

    // Responder state, owned by the environment process.
    logic       r_busy [N];
    logic [7:0] r_id   [N];
    int         r_cnt  [N];
    int         r_wait [N];
    int         r_k    [N];
    // Controls written by the main process.
    logic       hold   [N];
    logic       stray  [N];
    logic       sink_mode  = 1'b0;
    logic       sink_force = 1'b1;
    int         cyc = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(64'd200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        summary();
        $finish;
    end

    // Environment: variable-latency units and the token sink.
    initial begin
        for (int i = 0; i < 512; i++) tok_seen[i] = 0;
        for (int i = 0; i < N; i++) begin
            r_busy[i] = 1'b0; r_id[i] = '0; r_cnt[i] = 0; r_wait[i] = 0; r_k[i] = 0;
            hold[i] = 1'b0; stray[i] = 1'b0;
        end
        unit_ready_i = '1; res_valid_i = '0; res_last_i = '0; res_void_i = '0;
        res_data_i = '0; tok_ready_i = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            for (int i = 0; i < N; i++) begin
                res_void_i[i] = 1'b0;
                res_last_i[i] = 1'b1;
                if (!r_busy[i]) begin
                    unit_ready_i[i] = 1'b1;
                    res_valid_i[i]  = stray[i];
                    res_data_i[i*TW +: TW] = 16'hEE00 | 16'(i);
                end else begin
                    unit_ready_i[i] = 1'b0;
                    if (r_wait[i] > 0) begin
                        r_wait[i]--;
                        res_valid_i[i] = 1'b0;
                    end else if (hold[i]) begin
                        res_valid_i[i] = 1'b0;
                    end else begin
                        res_valid_i[i] = 1'b1;
                        res_void_i[i]  = (r_cnt[i] == 0);
                        res_last_i[i]  = (r_cnt[i] == 0) || (r_k[i] == r_cnt[i] - 1);
                        res_data_i[i*TW +: TW] = {r_id[i], 8'(r_k[i])};
                    end
                end
            end
            tok_ready_i = sink_mode ? sink_force : ((cyc % 3) != 2);
            #8;
            if (rst) begin
                for (int i = 0; i < N; i++) r_busy[i] = 1'b0;
            end else begin
                for (int i = 0; i < N; i++) begin
                    if (unit_valid_o[i] && r_busy[i]) busy_offer_viol++;
                    if (!r_busy[i] && res_valid_i[i] && res_ready_o[i]) stray_taken++;
                    if (r_busy[i] && res_valid_i[i] && res_ready_o[i]) begin
                        if (res_last_i[i]) r_busy[i] = 1'b0;
                        else r_k[i]++;
                    end else if (!r_busy[i] && unit_valid_o[i] && unit_ready_i[i]) begin
                        r_busy[i] = 1'b1;
                        r_id[i]   = unit_pkg_o[i*PW+8 +: 8];
                        r_cnt[i]  = int'(unit_pkg_o[i*PW+6 +: 2]);
                        r_wait[i] = int'(unit_pkg_o[i*PW +: 6]);
                        r_k[i]    = 0;
                    end
                end
                if (tok_valid_o && tok_ready_i) begin
                    tok_n++;
                    if (tok_data_o[7:0] > 8'd1) bad_tok++;
                    else tok_seen[{tok_data_o[15:8], tok_data_o[0]}]++;
                end
            end
        end
    end

    initial begin
        int tok_total;
        logic [7:0] order [0:8];
        order = '{8'h44, 8'h45, 8'h46, 8'h47, 8'h48, 8'h49, 8'h40, 8'h41, 8'h42};

        // Reset state (R1) and pool size (R11)
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #6;
        chk(pkg_ready_o == 1'b1, "R1 pkg_ready after reset", pkg_ready_o, 1);
        chk(unit_valid_o == '0, "R1 unit_valid after reset", unit_valid_o, 0);
        chk(res_ready_o == '0, "R1 res_ready after reset", res_ready_o, 0);
        chk(tok_valid_o == 1'b0, "R1 tok_valid after reset", tok_valid_o, 0);
        chk($bits(unit_valid_o) == 10, "R11 default pool size", $bits(unit_valid_o), 10);

        // Vector table walk: every token forwarded exactly once (R6, R7)
        tok_total = 0;
        for (int v = 0; v < NV; v++) begin
            bit taken;
            taken = 1'b0;
            tok_total += int'(VEC[v][7:6]);
            while (!taken) begin
                @(negedge clk);
                pkg_valid_i = 1'b1;
                pkg_data_i  = VEC[v];
                #6;
                taken = pkg_ready_o;
            end
        end
        @(negedge clk);
        pkg_valid_i = 1'b0;
        repeat (150) @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < 2; k++) begin
                int exp_n;
                exp_n = (k < int'(VEC[v][7:6])) ? 1 : 0;
                chk(tok_seen[{VEC[v][15:8], k[0]}] == exp_n, "R6 token count per result",
                    tok_seen[{VEC[v][15:8], k[0]}], exp_n);
            end
        end
        chk(tok_n == tok_total, "R6 total tokens", tok_n, tok_total);
        chk(bad_tok == 0, "R6 malformed tokens", bad_tok, 0);

        // Directed: reset again, hold every unit's results
        sink_mode = 1'b1;
        sink_force = 1'b1;
        for (int i = 0; i < N; i++) hold[i] = 1'b1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // R3: dispatch order 0..N-1 from reset
        for (int j = 0; j < N; j++) begin
            @(negedge clk);
            pkg_valid_i = 1'b1;
            pkg_data_i  = {8'h40 + 8'(j), 2'd1, 6'd0};
            #6;
            chk(pkg_ready_o == 1'b1, "R3 ready while units free", pkg_ready_o, 1);
            chk(unit_valid_o == (N'(1) << j), "R3 round-robin unit offer", unit_valid_o, N'(1) << j);
        end

        // R4: pool full, void package waits
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            pkg_data_i = {8'h60, 2'd0, 6'd0};
            #6;
            chk(pkg_ready_o == 1'b0, "R4 stall when full", pkg_ready_o, 0);
            chk(unit_valid_o == '0, "R4 no offer when full", unit_valid_o, 0);
            if (s == 2) hold[3] = 1'b0;
        end

        // R5: last beat of unit 3 retires; not free in that cycle
        @(negedge clk); #6;
        chk(res_ready_o == N'(8), "R8 only unit 3 granted", res_ready_o, 8);
        chk(tok_valid_o && tok_data_o == 16'h4300, "R6 unit 3 token", tok_data_o, 16'h4300);
        chk(pkg_ready_o == 1'b0, "R5 not free while retiring", pkg_ready_o, 0);
        chk(unit_valid_o == '0, "R5 no offer while retiring", unit_valid_o, 0);
        @(negedge clk); #6;
        chk(pkg_ready_o == 1'b1, "R5 free next cycle", pkg_ready_o, 1);
        chk(unit_valid_o == N'(8), "R5 offer goes to unit 3", unit_valid_o, 8);

        // R7: void beat consumed with no token
        @(negedge clk);
        pkg_valid_i = 1'b0;
        #6;
        chk(tok_valid_o == 1'b0, "R7 void beat not forwarded", tok_valid_o, 0);
        chk(res_ready_o == N'(8), "R7 void beat accepted", res_ready_o, 8);
        @(negedge clk); #6;
        chk(pkg_ready_o == 1'b1, "R7 unit free after void", pkg_ready_o, 1);
        sink_force = 1'b0;
        stray[3] = 1'b1;
        for (int i = 0; i < N; i++) hold[i] = 1'b0;

        // R9: backpressure with nine units presenting
        for (int s = 0; s < 2; s++) begin
            @(negedge clk); #6;
            chk(tok_valid_o && tok_data_o == 16'h4400, "R8 first grant after pointer",
                tok_data_o, 16'h4400);
            chk(res_ready_o == '0, "R9 no accept under backpressure", res_ready_o, 0);
            if (s == 1) sink_force = 1'b1;
        end

        // R8 order and R10 stray from idle unit 3
        for (int s = 0; s < 9; s++) begin
            @(negedge clk); #6;
            chk(tok_valid_o && tok_data_o == {order[s], 8'h00}, "R8 round-robin token order",
                tok_data_o, {order[s], 8'h00});
            chk(res_ready_o[3] == 1'b0, "R10 idle unit result not taken", res_ready_o[3], 0);
        end
        @(negedge clk); #6;
        chk(tok_valid_o == 1'b0, "R10 idle unit result not forwarded", tok_valid_o, 0);
        chk(res_ready_o == '0, "R10 no accept from idle unit", res_ready_o, 0);
        stray[3] = 1'b0;
        @(negedge clk); #9;
        chk(stray_taken == 0, "R10 stray accept count", stray_taken, 0);
        chk(busy_offer_viol == 0, "R2 offers to busy units", busy_offer_viol, 0);

        summary();
        $finish;
    end

endmodule